// File: doc/BRIEF.md
# Symmetric Decimating FIR Channel Filter

This block filters one channel of signed 14-bit converter samples with a symmetric FIR whose twelve folded coefficients serve either a 24-tap or a 23-tap response. The output rate can be reduced by 2, 4 or 8, or kept at the input rate. Each coefficient is taken either from a small built-in set or from a per-coefficient programmed word. Which source is used depends on an enable flag inside that word.

A global enable adds a fixed processing delay to the channel. A per-channel use bit then chooses between the filter and a plain delay line of the same length. This keeps filtered and unfiltered channels aligned in time. With the global enable clear, samples pass straight through without delay.

Top module: `symfir_decim`

## Requirements
- R1: With `glb_en` = 0, `out_valid` equals `in_valid` and `out_data` equals `in_data` in the same cycle, with no register in the path.
- R2: With `glb_en` = 1 and `use_flt` = 0, every valid input sample appears unchanged on the output exactly 20 cycles later, with `out_valid` high.
- R3: With `glb_en` = 1 and `use_flt` = 1, a retained input sample gives its filtered result with `out_valid` high exactly 20 cycles after the sample was presented. All other cycles have `out_valid` low.
- R4: With `odd_tap` = 0, the result is sum over k = 0..11 of h_k·(x[n−k] + x[n−23+k]), where x[n] is the current sample and x[n−i] is the i-th earlier valid sample.
- R5: With `odd_tap` = 1, the result is sum over k = 0..10 of h_k·(x[n−k] + x[n−22+k]) plus h11·x[n−11].
- R6: Decimation is set by `rate_sel`: 000 keeps one sample in 2, 001 keeps one in 4, 100 keeps one in 8, and any other code keeps every sample. The first valid sample after reset is retained, and then every D-th valid sample after it. The tap history advances on every valid sample, retained or not.
- R7: When coefficient k (k = 0..11) comes from the built-in set s, let m = (k+1)², j = 11−k, with j0 and j1 the low two bits of j. The sets give: s0 = +14m; s1 = 14m, negated when j0 = 1; s2 = +7m; s3 = 14m, negated when j1 = 1; s4 = 14m, negated when j1 XOR j0 = 1; s5 = 7m, negated when j0 = 1. Sets 6 and 7 are all zero.
- R8: `cust_words` holds twelve 16-bit words, with word k in bits [16k+15:16k]. When bit 15 of word k is 1, h_k is the signed 12-bit value in bits 11:0 of that word. When bit 15 is 0, h_k is the built-in value from R7, whatever bits 11:0 hold.
- R9: The output equals floor(sum / 2048), saturated to the range −8192..8191.
- R10: A synchronous reset clears the tap history to zero and clears the decimation phase. No `out_valid` is produced from a pipeline stage until new samples arrive.
- R11: While `use_flt` = 0, the settings of `odd_tap`, `rate_sel` and `coef_set` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Signed input sample |
| glb_en | input | 1 | Global processing enable (adds the fixed delay) |
| use_flt | input | 1 | Route this channel through the filter |
| odd_tap | input | 1 | 1 selects the 23-tap form, 0 the 24-tap form |
| rate_sel | input | 3 | Decimation code |
| coef_set | input | 3 | Built-in coefficient set |
| cust_words | input | 192 | Twelve programmed coefficient words |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 14 | Signed output sample |

## Verification
Inputs are applied on the falling edge. Outputs are read 1 ns later in every cycle. In pass-through mode the expected value is due in the same cycle. In both the filter mode and the delay-line mode it is due 20 cycles after the input cycle. The reference model writes each expected strobe and value into a ring slot 20 cycles ahead, or into the current slot when the global enable is clear. Each cycle compares `out_valid` against its slot, and compares `out_data` when a strobe is expected. Every configuration starts from a reset and ends with 24 idle cycles, so no result from one setting spills into the next.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    localparam int DW          = 14;
    localparam int CW          = 12;
    localparam int NC          = 12;
    localparam int NTAP        = 2 * NC;
    localparam int HIST        = NTAP - 1;
    localparam int FRAC        = 11;
    localparam int LAT         = 20;
    localparam int WORD_W      = 16;
    localparam int CUST_EN_BIT = 15;
    localparam int PW          = DW + 1;
    localparam int MW          = PW + CW;
    localparam int AW          = MW + $clog2(NC);
    localparam int OUT_MAX     = (2 ** (DW - 1)) - 1;
    localparam int OUT_MIN     = -(2 ** (DW - 1));

    typedef logic signed [DW-1:0] samp_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [AW-1:0] acc_t;

    typedef struct packed {
        logic  vld;
        samp_t dat;
    } beat_t;

    typedef enum logic [2:0] {
        RATE_D2 = 3'b000,
        RATE_D4 = 3'b001,
        RATE_D1 = 3'b011,
        RATE_D8 = 3'b100
    } rate_e;

    // Low bits of the phase counter that must be zero for a retained sample.
    function automatic logic [2:0] phase_mask(input logic [2:0] code);
        case (rate_e'(code))
            RATE_D2: return 3'b001;
            RATE_D4: return 3'b011;
            RATE_D8: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    // Built-in coefficient k of set s: quadratic envelope with a sign pattern.
    function automatic coef_t preset_coef(input logic [2:0] s, input int k);
        int         sq;
        int         mag;
        logic [1:0] j;
        logic       neg;
        sq  = (k + 1) * (k + 1);
        j   = 2'(NC - 1 - k);
        mag = 0;
        neg = 1'b0;
        case (s)
            3'd0: begin mag = 14 * sq; neg = 1'b0;        end
            3'd1: begin mag = 14 * sq; neg = j[0];        end
            3'd2: begin mag = 7 * sq;  neg = 1'b0;        end
            3'd3: begin mag = 14 * sq; neg = j[1];        end
            3'd4: begin mag = 14 * sq; neg = j[1] ^ j[0]; end
            3'd5: begin mag = 7 * sq;  neg = j[0];        end
            default: begin mag = 0;    neg = 1'b0;        end
        endcase
        return coef_t'(neg ? -mag : mag);
    endfunction

    // Drop the fraction bits (floor) and clamp to the sample range.
    function automatic samp_t sat_round(input acc_t acc);
        acc_t sh;
        sh = acc >>> FRAC;
        if (sh > acc_t'(OUT_MAX)) return samp_t'(OUT_MAX);
        if (sh < acc_t'(OUT_MIN)) return samp_t'(OUT_MIN);
        return samp_t'(sh);
    endfunction

endpackage

// File: rtl/symfir_taps.sv
module symfir_taps
    import symfir_pkg::*;
#(
    parameter int DEPTH = HIST
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  samp_t din,
    output samp_t hist [1:DEPTH]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i <= DEPTH; i++) hist[i] <= '0;
        end else if (shift) begin
            hist[1] <= din;
            for (int i = 2; i <= DEPTH; i++) hist[i] <= hist[i-1];
        end
    end

    // R6: history advances on every valid sample
    a_r6_shift_every_sample: assert property (@(posedge clk) disable iff (rst)
        shift |=> hist[1] == $past(din));

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac
    import symfir_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  odd,
    input  coef_t coefs [NC],
    input  samp_t x0,
    input  samp_t hist [1:HIST],
    output logic  v1,
    output beat_t res
);

    samp_t                 xs     [0:HIST];
    logic signed [PW-1:0]  pre    [NC];
    logic signed [MW-1:0]  prod_q [NC];
    acc_t                  acc;

    always_comb begin
        xs[0] = x0;
        for (int i = 1; i <= HIST; i++) xs[i] = hist[i];
    end

    // Folded pre-add: each coefficient multiplies the sum of its mirrored pair.
    for (genvar k = 0; k < NC; k++) begin : g_fold
        samp_t mate;
        always_comb begin
            if (odd) mate = (k == NC - 1) ? samp_t'(0) : xs[NTAP-2-k];
            else     mate = xs[NTAP-1-k];
            pre[k] = $signed({xs[k][DW-1], xs[k]}) + $signed({mate[DW-1], mate});
        end

        always_ff @(posedge clk) begin
            if (rst) prod_q[k] <= '0;
            else     prod_q[k] <= MW'(pre[k]) * MW'(coefs[k]);
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NC; k++) acc = acc + AW'(prod_q[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1  <= 1'b0;
            res <= '0;
        end else begin
            v1      <= take;
            res.vld <= v1;
            res.dat <= sat_round(acc);
        end
    end

endmodule

// File: rtl/symfir_pipe.sv
module symfir_pipe
    import symfir_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t din,
    output beat_t dout
);

    if (DEPTH == 0) begin : g_wire
        assign dout = din;
    end else begin : g_regs
        beat_t st [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) st[i] <= '0;
            end else begin
                st[0] <= din;
                for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
            end
        end
        assign dout = st[DEPTH-1];
    end

endmodule

// File: rtl/symfir_decim.sv
module symfir_decim
    import symfir_pkg::*;
#(
    parameter int LATENCY = LAT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   in_data,
    input  logic                   glb_en,
    input  logic                   use_flt,
    input  logic                   odd_tap,
    input  logic [2:0]             rate_sel,
    input  logic [2:0]             coef_set,
    input  logic [NC*WORD_W-1:0]   cust_words,
    output logic                   out_valid,
    output logic signed [DW-1:0]   out_data
);

    localparam int FRONT = 2;
    localparam int TAIL  = LATENCY - FRONT;

    logic        flt_on;
    logic [2:0]  phase_q;
    logic        retain;
    coef_t       coefs [NC];
    samp_t       hist  [1:HIST];
    logic        mac_v1;
    beat_t       mac_res;
    beat_t       byp_in;
    beat_t       byp_res;
    beat_t       merged;
    beat_t       tail_out;
    logic [NC*3-1:0] unused_word_bits;

    assign flt_on = glb_en & use_flt;
    assign retain = in_valid & flt_on & ((phase_q & phase_mask(rate_sel)) == 3'b000);

    always_ff @(posedge clk) begin
        if (rst)                     phase_q <= 3'b000;
        else if (in_valid && flt_on) phase_q <= phase_q + 3'd1;
    end

    for (genvar k = 0; k < NC; k++) begin : g_coef
        logic [WORD_W-1:0] word;
        assign word = cust_words[k*WORD_W +: WORD_W];
        assign coefs[k] = word[CUST_EN_BIT] ? coef_t'(word[CW-1:0])
                                            : preset_coef(coef_set, k);
        assign unused_word_bits[k*3 +: 3] = word[CUST_EN_BIT-1:CW];
    end

    symfir_taps #(.DEPTH(HIST)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .shift (in_valid),
        .din   (in_data),
        .hist  (hist)
    );

    symfir_mac u_mac (
        .clk   (clk),
        .rst   (rst),
        .take  (retain),
        .odd   (odd_tap),
        .coefs (coefs),
        .x0    (in_data),
        .hist  (hist),
        .v1    (mac_v1),
        .res   (mac_res)
    );

    assign byp_in = '{vld: in_valid & glb_en & ~use_flt, dat: in_data};

    symfir_pipe #(.DEPTH(FRONT)) u_byp (
        .clk  (clk),
        .rst  (rst),
        .din  (byp_in),
        .dout (byp_res)
    );

    assign merged = mac_res.vld ? mac_res : byp_res;

    symfir_pipe #(.DEPTH(TAIL)) u_tail (
        .clk  (clk),
        .rst  (rst),
        .din  (merged),
        .dout (tail_out)
    );

    always_comb begin
        if (glb_en) begin
            out_valid = tail_out.vld;
            out_data  = tail_out.dat;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
        end
    end

    // R3: a filter stage-one strobe only follows a filtered input sample
    a_r3_retain_from_input: assert property (@(posedge clk) disable iff (rst)
        mac_v1 |-> $past(in_valid && glb_en && use_flt));

    // R6: with decimation active, the sample after a retained one is dropped
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (mac_v1 && flt_on && phase_mask(rate_sel) != 3'b000) |-> !retain);

    // R2: the delay path and the filter path never deliver in the same cycle
    a_r2_merge_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mac_res.vld && byp_res.vld));

endmodule

// File: tb/symfir_decim_tb.sv
module symfir_decim_tb;
    import symfir_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic signed [13:0]   in_data;
    logic                 glb_en;
    logic                 use_flt;
    logic                 odd_tap;
    logic [2:0]           rate_sel;
    logic [2:0]           coef_set;
    logic [191:0]         cust_words;
    logic                 out_valid;
    logic signed [13:0]   out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int hist_m [0:22];
    int phase_m;
    bit ev [64];
    int ed [64];
    int cyc = 0;

    always #4 clk = ~clk;

    symfir_decim u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .glb_en(glb_en), .use_flt(use_flt), .odd_tap(odd_tap),
        .rate_sel(rate_sel), .coef_set(coef_set), .cust_words(cust_words),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int ref_preset(int s, int k);
        int m;
        int j;
        m = (k + 1) * (k + 1);
        j = 11 - k;
        case (s)
            0: return 14 * m;
            1: return (j % 2 == 1) ? -14 * m : 14 * m;
            2: return 7 * m;
            3: return (((j >> 1) & 1) == 1) ? -14 * m : 14 * m;
            4: return ((((j >> 1) ^ j) & 1) == 1) ? -14 * m : 14 * m;
            5: return (j % 2 == 1) ? -7 * m : 7 * m;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_coef(int k);
        logic [15:0] w;
        logic signed [11:0] c;
        w = cust_words[k*16 +: 16];
        c = w[11:0];
        if (w[15]) return int'(c);
        return ref_preset(int'(coef_set), k);
    endfunction

    function automatic int xat(int i, int cur);
        return (i == 0) ? cur : hist_m[i-1];
    endfunction

    function automatic int ref_filter(int cur);
        longint acc;
        longint y;
        acc = 0;
        if (odd_tap) begin
            for (int k = 0; k < 11; k++)
                acc += longint'(ref_coef(k)) * longint'(xat(k, cur) + xat(22 - k, cur));
            acc += longint'(ref_coef(11)) * longint'(xat(11, cur));
        end else begin
            for (int k = 0; k < 12; k++)
                acc += longint'(ref_coef(k)) * longint'(xat(k, cur) + xat(23 - k, cur));
        end
        y = acc >>> 11;
        if (y > 8191) y = 8191;
        if (y < -8192) y = -8192;
        return int'(y);
    endfunction

    function automatic int ref_ratio(logic [2:0] code);
        case (code)
            3'b000: return 2;
            3'b001: return 4;
            3'b100: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int rnd_sample();
        int r;
        r = int'($urandom % 16);
        if (r == 0) return 8191;
        if (r == 1) return -8192;
        return int'($urandom % 16384) - 8192;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic step(bit v, int d, string tag);
        int t;
        int s;
        bit ret;
        in_valid = v;
        in_data  = 14'(d);
        s = cyc % 64;
        t = (cyc + 20) % 64;
        if (!glb_en) begin
            ev[s] = v;
            ed[s] = d;
        end else if (use_flt) begin
            ev[t] = 1'b0;
            if (v) begin
                ret = (phase_m % ref_ratio(rate_sel)) == 0;
                ev[t] = ret;
                if (ret) ed[t] = ref_filter(d);
                phase_m++;
            end
        end else begin
            ev[t] = v;
            ed[t] = d;
        end
        if (v) begin
            for (int i = 22; i > 0; i--) hist_m[i] = hist_m[i-1];
            hist_m[0] = d;
        end
        #1;
        chk(tag, "valid", int'(out_valid), int'(ev[s]));
        if (ev[s]) chk(tag, "data", int'(out_data), ed[s]);
        ev[s] = 1'b0;
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 23; i++) hist_m[i] = 0;
        for (int i = 0; i < 64; i++) ev[i] = 1'b0;
        phase_m = 0;
        #1;
        // R10: nothing valid leaves the pipeline right after reset
        if (glb_en) chk("R10", "reset valid", int'(out_valid), 0);
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(($urandom % 4) != 0, rnd_sample(), tag);
        for (int i = 0; i < 24; i++) step(1'b0, 0, tag);
    endtask

    task automatic setup(bit en, bit use_f, bit odd, logic [2:0] rate, logic [2:0] cs);
        glb_en   = en;
        use_flt  = use_f;
        odd_tap  = odd;
        rate_sel = rate;
        coef_set = cs;
        do_reset();
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink  = $urandom(32'd9157);
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_data    = '0;
        cust_words = '0;
        glb_en     = 1'b0;
        use_flt    = 1'b0;
        odd_tap    = 1'b0;
        rate_sel   = 3'b000;
        coef_set   = 3'b000;
        @(negedge clk);

        // R1: pass-through with the global enable clear
        setup(1'b0, 1'b1, 1'b1, 3'b001, 3'd2);
        run(40, "R1");

        // R2 and R11: delay line, filter settings must have no effect
        setup(1'b1, 1'b0, 1'b1, 3'b100, 3'd3);
        run(60, "R2/R11");

        // R3, R4, R7: 24-tap, no decimation, set 0
        setup(1'b1, 1'b1, 1'b0, 3'b011, 3'd0);
        run(80, "R3/R4/R7");

        // R5, R6: 23-tap, decimate by 2, set 1
        setup(1'b1, 1'b1, 1'b1, 3'b000, 3'd1);
        run(80, "R5/R6/R7");

        // R4, R6: 24-tap, decimate by 4, set 3
        setup(1'b1, 1'b1, 1'b0, 3'b001, 3'd3);
        run(100, "R4/R6/R7");

        // R8: mixed programmed and built-in coefficients, decimate by 8, set 4
        for (int k = 0; k < 12; k++)
            cust_words[k*16 +: 16] = {1'(k % 2), 3'b000, 12'($urandom)};
        setup(1'b1, 1'b1, 1'b1, 3'b100, 3'd4);
        run(120, "R5/R6/R8");

        // R9: saturation at both rails with full-scale programmed coefficients
        for (int k = 0; k < 12; k++) cust_words[k*16 +: 16] = {1'b1, 3'b000, 12'h7FF};
        setup(1'b1, 1'b1, 1'b0, 3'b011, 3'd0);
        for (int i = 0; i < 30; i++) step(1'b1, 8191, "R9");
        for (int i = 0; i < 30; i++) step(1'b1, -8192, "R9");
        for (int i = 0; i < 24; i++) step(1'b0, 0, "R9");

        // R6, R7: unlisted rate code keeps every sample, set 5, 23-tap
        cust_words = '0;
        setup(1'b1, 1'b1, 1'b1, 3'b010, 3'd5);
        run(60, "R6/R7");

        // R7: set 2, 24-tap; bit 15 clear with nonzero low bits still uses built-in (R8)
        for (int k = 0; k < 12; k++) cust_words[k*16 +: 16] = {1'b0, 3'b000, 12'($urandom)};
        setup(1'b1, 1'b1, 1'b0, 3'b011, 3'd2);
        run(60, "R7/R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule